// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This block makes the three per-descriptor decisions that a descriptor-driven DMA channel takes after each command: whether to raise an interrupt, whether to hold the descriptor and retry it later, and where the command pointer goes next. The decisions use three small condition fields from the descriptor's command word, three select registers and the channel's four device-status bits. Descriptor fetch, status writeback and data movement belong to other blocks.

Each action has its own select register. A select register holds a 4-bit mask and a 4-bit compare value. The action's condition is true when the device status under the mask equals the compare value under the same mask. The action's 2-bit code then says what to do: never act, act when the condition holds, act when it does not, or always act.

The channel sequencer presents a descriptor and pulses `evalValid` for one cycle. One cycle later the block shows its results. A wait decision freezes the pointer and the branch-taken flag, so the same descriptor can be presented again. Otherwise the pointer either jumps to the descriptor's branch target or steps to the next 16-byte descriptor.

Top module: `desc_cond_unit`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `irqPulse`, `waitFlag` and `branchTaken` are 0 and `nextPtr` is 0.
- R2: `cmdCond` carries the wait code in bits 1:0, the branch code in bits 3:2 and the interrupt code in bits 5:4. The codes are 2'b00 never act, 2'b01 act if the condition is true, 2'b10 act if the condition is false, and 2'b11 always act.
- R3: Each select input holds its mask in bits 19:16 and its compare value in bits 3:0. An action's condition is true when `(devStatus & mask) == (value & mask)`. The interrupt, branch and wait actions use `intSel`, `brSel` and `waitSel` respectively. A zero mask makes the condition true.
- R4: When an evaluation does not wait and the branch decision is true, `nextPtr` equals the `branchTarget` presented with it and `branchTaken` is 1, starting from the cycle after `evalValid`.
- R5: When an evaluation does not wait and the branch decision is false, `nextPtr` equals the presented `cmdPtr` plus 16 and `branchTaken` is 0, starting from the cycle after `evalValid`.
- R6: When the wait decision is true, `waitFlag` is 1 in the cycle after `evalValid`. In that case `nextPtr` and `branchTaken` keep their previous values and no interrupt pulse is raised, whatever the branch and interrupt codes say.
- R7: `irqPulse` is high for exactly the one cycle after an `evalValid` whose wait decision is false and whose interrupt decision is true. It is low in every other cycle.
- R8: `waitFlag` is rewritten at every evaluation and holds its value between evaluations.
- R9: While `evalValid` is low, changes on the other inputs do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | One-cycle strobe: evaluate the presented descriptor |
| cmdCond | input | 6 | Condition codes from the command word (interrupt 5:4, branch 3:2, wait 1:0) |
| intSel | input | 32 | Interrupt select: mask 19:16, value 3:0 |
| waitSel | input | 32 | Wait select: mask 19:16, value 3:0 |
| brSel | input | 32 | Branch select: mask 19:16, value 3:0 |
| devStatus | input | 4 | Channel device-status bits |
| cmdPtr | input | 32 | Address of the current descriptor |
| branchTarget | input | 32 | Branch-target word of the current descriptor |
| irqPulse | output | 1 | One-cycle interrupt request |
| waitFlag | output | 1 | The last evaluation chose to wait |
| nextPtr | output | 32 | Next command pointer |
| branchTaken | output | 1 | The last pointer update was a branch |

## Verification
A wrong decision inside the block shows at the ports one cycle after `evalValid`, in one of four ways: a pointer that is wrong by exactly 16 bytes or that equals the target when it should not, a flipped `branchTaken`, a missing or extra `irqPulse`, or a `waitFlag` that disagrees with the masked status. A wait that wrongly leaves the pointer alone, or a non-wait that wrongly freezes it, shows in `nextPtr` in that same cycle. A mix-up between the three select registers only shows when the three registers disagree, so the stimulus has to give them different values for the same status.

// File: rtl/desc_cond_pkg.sv
package desc_cond_pkg;

  localparam int PTR_W      = 32;
  localparam int SEL_W      = 32;
  localparam int STAT_W     = 4;
  localparam int MASK_LSB   = 16;
  localparam int DESC_BYTES = 16;
  localparam int CODE_W     = 2;
  localparam int N_ACTIONS  = 3;
  localparam int COND_W     = CODE_W * N_ACTIONS;

  // action slots; the slot index times CODE_W is the field position in the command word
  localparam int ACT_WAIT = 0;
  localparam int ACT_BR   = 1;
  localparam int ACT_IRQ  = 2;

  typedef enum logic [CODE_W-1:0] {
    CondNever   = 2'b00,
    CondIfTrue  = 2'b01,
    CondIfFalse = 2'b10,
    CondAlways  = 2'b11
  } condCode_e;

  typedef struct packed {
    logic load;
    logic setWait;
    logic takeBranch;
    logic advance;
    logic irqFire;
  } ctrlStrobe_t;

endpackage

// File: rtl/desc_cond_decide.sv
module desc_cond_decide
  import desc_cond_pkg::*;
#(
  parameter int SEL_BITS  = SEL_W,
  parameter int STAT_BITS = STAT_W,
  parameter int MASK_POS  = MASK_LSB
) (
  input  logic [CODE_W-1:0]    code,
  input  logic [SEL_BITS-1:0]  sel,
  input  logic [STAT_BITS-1:0] status,
  output logic                 act
);

  logic [STAT_BITS-1:0] selMask;
  logic [STAT_BITS-1:0] selValue;
  logic                 condTrue;
  logic                 unusedSelBits;

  assign selMask  = sel[MASK_POS +: STAT_BITS];
  assign selValue = sel[STAT_BITS-1:0];
  assign unusedSelBits = ^{sel[SEL_BITS-1:MASK_POS+STAT_BITS], sel[MASK_POS-1:STAT_BITS]};

  assign condTrue = ((status & selMask) == (selValue & selMask));

  always_comb begin
    unique case (condCode_e'(code))
      CondNever:   act = 1'b0;
      CondIfTrue:  act = condTrue;
      CondIfFalse: act = ~condTrue;
      CondAlways:  act = 1'b1;
      default:     act = 1'b0;
    endcase
  end

endmodule

// File: rtl/desc_cond_ctrl.sv
module desc_cond_ctrl
  import desc_cond_pkg::*;
#(
  parameter int SEL_BITS  = SEL_W,
  parameter int STAT_BITS = STAT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evalValid,
  input  logic [COND_W-1:0]    cmdCond,
  input  logic [SEL_BITS-1:0]  intSel,
  input  logic [SEL_BITS-1:0]  waitSel,
  input  logic [SEL_BITS-1:0]  brSel,
  input  logic [STAT_BITS-1:0] devStatus,
  output ctrlStrobe_t          strobe
);

  logic [SEL_BITS-1:0] selArr [N_ACTIONS];
  logic [N_ACTIONS-1:0] actDecide;

  always_comb begin
    selArr[ACT_WAIT] = waitSel;
    selArr[ACT_BR]   = brSel;
    selArr[ACT_IRQ]  = intSel;
  end

  for (genvar k = 0; k < N_ACTIONS; k++) begin : g_decide
    desc_cond_decide #(
      .SEL_BITS (SEL_BITS),
      .STAT_BITS(STAT_BITS),
      .MASK_POS (MASK_LSB)
    ) u_decide (
      .code  (cmdCond[k*CODE_W +: CODE_W]),
      .sel   (selArr[k]),
      .status(devStatus),
      .act   (actDecide[k])
    );
  end

  logic doWait;
  logic proceed;

  assign doWait  = evalValid & actDecide[ACT_WAIT];
  assign proceed = evalValid & ~actDecide[ACT_WAIT];

  always_comb begin
    strobe            = '0;
    strobe.load       = evalValid;
    strobe.setWait    = doWait;
    strobe.irqFire    = proceed & actDecide[ACT_IRQ];
    strobe.takeBranch = proceed & actDecide[ACT_BR];
    strobe.advance    = proceed & ~actDecide[ACT_BR];
  end

  AST_WAIT_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setWait |-> !strobe.irqFire); // R6
  AST_ONE_PTR_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setWait, strobe.takeBranch, strobe.advance})); // R6
  AST_STROBE_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |-> !(strobe.irqFire || strobe.takeBranch || strobe.advance || strobe.setWait)); // R9

endmodule

// File: rtl/desc_cond_dp.sv
module desc_cond_dp
  import desc_cond_pkg::*;
#(
  parameter int PTR_BITS = PTR_W,
  parameter int STEP     = DESC_BYTES
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [PTR_BITS-1:0] cmdPtr,
  input  logic [PTR_BITS-1:0] branchTarget,
  output logic                irqPulse,
  output logic                waitFlag,
  output logic [PTR_BITS-1:0] nextPtr,
  output logic                branchTaken
);

  localparam logic [PTR_BITS-1:0] PtrStep = PTR_BITS'(STEP);

  logic [PTR_BITS-1:0] seqPtr;
  assign seqPtr = cmdPtr + PtrStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse    <= 1'b0;
      waitFlag    <= 1'b0;
      nextPtr     <= '0;
      branchTaken <= 1'b0;
    end else begin
      irqPulse <= strobe.irqFire;
      if (strobe.load) begin
        waitFlag <= strobe.setWait;
      end
      if (strobe.takeBranch) begin
        nextPtr     <= branchTarget;
        branchTaken <= 1'b1;
      end else if (strobe.advance) begin
        nextPtr     <= seqPtr;
        branchTaken <= 1'b0;
      end
    end
  end

  AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeBranch |=> (nextPtr == $past(branchTarget)) && branchTaken); // R4
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (nextPtr == $past(cmdPtr) + PtrStep) && !branchTaken); // R5
  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setWait |=> $stable(nextPtr) && $stable(branchTaken) && waitFlag && !irqPulse); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.irqFire |=> !irqPulse); // R7
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(waitFlag) && $stable(nextPtr)); // R8

endmodule

// File: rtl/desc_cond_unit.sv
module desc_cond_unit
  import desc_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalValid,
  input  logic [COND_W-1:0] cmdCond,
  input  logic [SEL_W-1:0]  intSel,
  input  logic [SEL_W-1:0]  waitSel,
  input  logic [SEL_W-1:0]  brSel,
  input  logic [STAT_W-1:0] devStatus,
  input  logic [PTR_W-1:0]  cmdPtr,
  input  logic [PTR_W-1:0]  branchTarget,
  output logic              irqPulse,
  output logic              waitFlag,
  output logic [PTR_W-1:0]  nextPtr,
  output logic              branchTaken
);

  ctrlStrobe_t strobe;

  desc_cond_ctrl #(
    .SEL_BITS (SEL_W),
    .STAT_BITS(STAT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evalValid(evalValid),
    .cmdCond  (cmdCond),
    .intSel   (intSel),
    .waitSel  (waitSel),
    .brSel    (brSel),
    .devStatus(devStatus),
    .strobe   (strobe)
  );

  desc_cond_dp #(
    .PTR_BITS(PTR_W),
    .STEP    (DESC_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdPtr      (cmdPtr),
    .branchTarget(branchTarget),
    .irqPulse    (irqPulse),
    .waitFlag    (waitFlag),
    .nextPtr     (nextPtr),
    .branchTaken (branchTaken)
  );

endmodule

// File: tb/tb_desc_cond_unit.sv
module tb_desc_cond_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evalValid = 1'b0;
  logic [5:0]  cmdCond = '0;
  logic [31:0] intSel = '0;
  logic [31:0] waitSel = '0;
  logic [31:0] brSel = '0;
  logic [3:0]  devStatus = '0;
  logic [31:0] cmdPtr = '0;
  logic [31:0] branchTarget = '0;
  logic        irqPulse;
  logic        waitFlag;
  logic [31:0] nextPtr;
  logic        branchTaken;

  int checks = 0;
  int failures = 0;
  logic [31:0] expPtr = '0;
  logic        expBt = 1'b0;

  always #5 clk = ~clk;

  desc_cond_unit dut (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .cmdCond(cmdCond),
    .intSel(intSel), .waitSel(waitSel), .brSel(brSel), .devStatus(devStatus),
    .cmdPtr(cmdPtr), .branchTarget(branchTarget), .irqPulse(irqPulse),
    .waitFlag(waitFlag), .nextPtr(nextPtr), .branchTaken(branchTaken)
  );

  // vector: cmd[20:15] status[14:11] mask[10:7] value[6:3] irq[2] wait[1] branch[0]
  localparam int NVEC = 11;
  localparam logic [20:0] VEC [NVEC] = '{
    {6'b000000, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0},
    {6'b111100, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b1},
    {6'b010100, 4'h5, 4'hF, 4'h5, 1'b1, 1'b0, 1'b1},
    {6'b010100, 4'h4, 4'hF, 4'h5, 1'b0, 1'b0, 1'b0},
    {6'b101000, 4'h4, 4'hF, 4'h5, 1'b1, 1'b0, 1'b1},
    {6'b011000, 4'hD, 4'h3, 4'h1, 1'b1, 1'b0, 1'b0},
    {6'b111111, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0},
    {6'b111101, 4'h8, 4'h8, 4'h8, 1'b0, 1'b1, 1'b0},
    {6'b111101, 4'h0, 4'h8, 4'h8, 1'b1, 1'b0, 1'b1},
    {6'b100100, 4'h3, 4'h0, 4'hF, 1'b0, 1'b0, 1'b1},
    {6'b110010, 4'h0, 4'h1, 4'h1, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkSel(input logic [3:0] m, input logic [3:0] v);
    return {12'h0, m, 12'h0, v};
  endfunction

  // present one descriptor, then sample in the cycle after the evaluation edge
  task automatic evalOnce(input logic [5:0] cc, input logic [3:0] st,
                          input logic [31:0] iS, input logic [31:0] wS,
                          input logic [31:0] bS, input logic [31:0] ptr,
                          input logic [31:0] tgt, input logic eIrq,
                          input logic eWait, input logic eBr);
    @(negedge clk);
    cmdCond = cc; devStatus = st; intSel = iS; waitSel = wS; brSel = bS;
    cmdPtr = ptr; branchTarget = tgt; evalValid = 1'b1;
    @(negedge clk);
    evalValid = 1'b0;
    if (!eWait) begin
      if (eBr) begin expPtr = tgt; expBt = 1'b1; end
      else begin expPtr = ptr + 32'd16; expBt = 1'b0; end
    end
    check("R7", "irqPulse", {31'd0, irqPulse}, {31'd0, eIrq});
    check("R6", "waitFlag", {31'd0, waitFlag}, {31'd0, eWait});
    check(eWait ? "R6" : (eBr ? "R4" : "R5"), "nextPtr", nextPtr, expPtr);
    check(eWait ? "R6" : (eBr ? "R4" : "R5"), "branchTaken", {31'd0, branchTaken}, {31'd0, expBt});
    @(negedge clk);
    check("R7", "irqPulse second cycle", {31'd0, irqPulse}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "irqPulse", {31'd0, irqPulse}, 32'd0);
    check("R1", "waitFlag", {31'd0, waitFlag}, 32'd0);
    check("R1", "nextPtr", nextPtr, 32'd0);
    check("R1", "branchTaken", {31'd0, branchTaken}, 32'd0);
    rstN = 1'b1;

    // R2 R3 R4 R5 R6 R7 table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] v;
      logic [31:0] s;
      v = VEC[i];
      s = mkSel(v[10:7], v[6:3]);
      evalOnce(v[20:15], v[14:11], s, s, s, 32'h100 + i * 32'h20,
               32'hA000 + i * 32'h10, v[2], v[1], v[0]);
    end

    // R9 / R8: idle with wild inputs, outputs must hold (waitFlag still 1)
    @(negedge clk);
    cmdCond = 6'b111100; devStatus = 4'hF; cmdPtr = 32'hDEAD0000;
    branchTarget = 32'hBEEF0000; intSel = '1; waitSel = '1; brSel = '1;
    repeat (3) @(negedge clk);
    check("R9", "irqPulse idle", {31'd0, irqPulse}, 32'd0);
    check("R8", "waitFlag held", {31'd0, waitFlag}, 32'd1);
    check("R9", "nextPtr idle", nextPtr, expPtr);
    check("R9", "branchTaken idle", {31'd0, branchTaken}, {31'd0, expBt});

    // R3 each action uses its own select register
    evalOnce(6'b010101, 4'h2, mkSel(4'hF, 4'h2), mkSel(4'hF, 4'h9), mkSel(4'hF, 4'h7),
             32'h2000, 32'h3000, 1'b1, 1'b0, 1'b0);
    evalOnce(6'b010101, 4'h9, mkSel(4'hF, 4'h2), mkSel(4'hF, 4'h9), mkSel(4'hF, 4'h7),
             32'h2100, 32'h3100, 1'b0, 1'b1, 1'b0);
    evalOnce(6'b010101, 4'h7, mkSel(4'hF, 4'h2), mkSel(4'hF, 4'h9), mkSel(4'hF, 4'h7),
             32'h2200, 32'h3200, 1'b0, 1'b0, 1'b1);
    // R3 select bits outside the mask and value fields are ignored
    evalOnce(6'b010100, 4'h6, 32'hFFF6FFF6 & 32'hFFF6FFF6, mkSel(4'h0, 4'h0),
             32'hFFF6FFF6, 32'h2300, 32'h3300, 1'b1, 1'b0, 1'b1);

    // R1 mid-run reset clears state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "nextPtr after reset", nextPtr, 32'd0);
    check("R1", "branchTaken after reset", {31'd0, branchTaken}, 32'd0);
    rstN = 1'b1;
    expPtr = '0; expBt = 1'b0;
    // R5 step from reset state
    evalOnce(6'b000000, 4'h0, '0, '0, '0, 32'hFFFFFFF0, 32'h0, 1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule